// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one channel of a memory-to-memory copy engine. Software programs a source address, a destination address, a transfer count and a control word through a small register port. Setting the channel enable snapshots the programmed addresses and count into private working registers. Each pulse on the trigger input then runs a full sequence of transfers. A transfer is one read from the working source address followed by one write of the returned data to the working destination address. Transfers are 16 or 32 bits wide. After each write, both working addresses move up, move down or stay put, as their control fields select.

Repeat operation lets one setup fire again on every later trigger. On such a start only the count is refreshed from its register, so the addresses carry on from where the previous run stopped. The exception is the reloading destination mode, which also restarts the destination from its register. When a run ends the block gives a one-cycle completion pulse, and an optional interrupt pulse. It also drops the enable by itself unless repeat is selected.

Top module: `dma_xfer_engine`

## Requirements
- R1: The register port selects the source address (0), destination address (1), count (2) and control word (3), and reads back the same selections. All four read zero after reset. Control bits 4:0 always read zero and have no effect.
- R2: A control write that sets bit 15 while the enable is clear copies the source, destination and count registers into the working registers. A trigger starts a run only while the enable reads set and no run is active. A later enable starts again from the register values.
- R3: Each transfer reads from the working source address and then writes the returned read data to the working destination address. bus_size equals control bit 10 (0 selects 16-bit, 1 selects 32-bit).
- R4: Control bits 6:5 step the destination after each write: 0 adds the unit size, 1 subtracts it, 2 holds, and 3 adds and marks the destination for reload on repeat.
- R5: Control bits 8:7 step the source the same way for codes 0, 1 and 2. Code 3 holds the source.
- R6: The unit size is 2 bytes in 16-bit mode and 4 bytes in 32-bit mode.
- R7: With the default parameter CHANNEL=0, only the low 14 bits of the count register are kept, and a value of 0 runs 16384 transfers. With CHANNEL=3 all 16 bits are kept, and 0 means 65536.
- R8: A trigger after a completed run with repeat (control bit 9) reloads only the count. The source and destination continue from the previous run, except that destination code 3 restarts the destination from its register.
- R9: At completion the enable (control bit 15) clears if repeat is off, and stays set if repeat is on.
- R10: busy is high from the first read until the last write is acknowledged. done pulses for one cycle as busy falls. irq pulses together with done only when control bit 14 is set.
- R11: The bus address has bit 0 forced to zero in 16-bit mode, and bits 1:0 forced to zero in 32-bit mode.
- R12: A request holds its address, direction and data until bus_ack is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Register write select |
| reg_wdata | input | 32 | Register write data |
| reg_rsel | input | 2 | Register read select |
| reg_rdata | output | 32 | Register read data |
| trig | input | 1 | Start request |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_size | output | 1 | 1 for 32-bit, 0 for 16-bit |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Request accepted |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A fault in the working registers shows at the bus on the next request. A wrong step or a missed reload gives a wrong address in the transfer that follows, and a corrupted held read word gives wrong write data in that same transfer. A wrong working count appears only at the end of the run, as a wrong number of writes or a misplaced done pulse, so counts of 1, 2 and 16384 are each exercised. A missed enable clear shows on the control readback right after done.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   typedef enum logic [1:0] {
      STEP_INC     = 2'd0,
      STEP_DEC     = 2'd1,
      STEP_HOLD    = 2'd2,
      STEP_INC_RLD = 2'd3
   } step_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } seq_e;

   localparam logic [1:0] SEL_SRC  = 2'd0;
   localparam logic [1:0] SEL_DST  = 2'd1;
   localparam logic [1:0] SEL_CNT  = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   localparam int CB_DSTEP = 5;
   localparam int CB_SSTEP = 7;
   localparam int CB_RPT   = 9;
   localparam int CB_WORD  = 10;
   localparam int CB_IRQ   = 14;
   localparam int CB_EN    = 15;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter bit IS_SRC = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  step_e             mode,
   input  logic              word,
   output logic [ADDR_W-1:0] nxt
);
   logic [ADDR_W-1:0] stride;
   logic [ADDR_W-1:0] code3;

   assign stride = word ? ADDR_W'(4) : ADDR_W'(2);

   generate
      if (IS_SRC) begin : g_src
         assign code3 = addr;
      end else begin : g_dst
         assign code3 = addr + stride;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         STEP_INC:  nxt = addr + stride;
         STEP_DEC:  nxt = addr - stride;
         STEP_HOLD: nxt = addr;
         default:   nxt = code3;
      endcase
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CNT_BITS = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [1:0]          wsel,
   input  logic [31:0]         wdata,
   input  logic [1:0]          rsel,
   output logic [31:0]         rdata,
   input  logic                hw_en_clr,
   output logic [ADDR_W-1:0]   src_q,
   output logic [ADDR_W-1:0]   dst_q,
   output logic [CNT_BITS-1:0] cnt_q,
   output step_e               dmode,
   output step_e               smode,
   output logic                rpt,
   output logic                word,
   output logic                irq_en,
   output logic                en,
   output logic                en_rise
);
   logic [15:5] ctrl_q;

   assign en_rise = we && (wsel == SEL_CTRL) && wdata[CB_EN] && !ctrl_q[CB_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (hw_en_clr) ctrl_q[CB_EN] <= 1'b0;
         if (we) begin
            unique case (wsel)
               SEL_SRC: src_q  <= wdata[ADDR_W-1:0];
               SEL_DST: dst_q  <= wdata[ADDR_W-1:0];
               SEL_CNT: cnt_q  <= wdata[CNT_BITS-1:0];
               default: ctrl_q <= wdata[15:5];
            endcase
         end
      end
   end

   always_comb begin
      unique case (rsel)
         SEL_SRC: rdata = 32'(src_q);
         SEL_DST: rdata = 32'(dst_q);
         SEL_CNT: rdata = 32'(cnt_q);
         default: rdata = {16'h0, ctrl_q, 5'b0};
      endcase
   end

   assign dmode  = step_e'(ctrl_q[CB_DSTEP+1:CB_DSTEP]);
   assign smode  = step_e'(ctrl_q[CB_SSTEP+1:CB_SSTEP]);
   assign rpt    = ctrl_q[CB_RPT];
   assign word   = ctrl_q[CB_WORD];
   assign irq_en = ctrl_q[CB_IRQ];
   assign en     = ctrl_q[CB_EN];
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
   import dma_chan_pkg::*;
#(
   parameter int CHANNEL = 0,
   parameter int ADDR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_wsel,
   input  logic [31:0]       reg_wdata,
   input  logic [1:0]        reg_rsel,
   output logic [31:0]       reg_rdata,
   input  logic              trig,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_size,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic [31:0]       bus_rdata,
   input  logic              bus_ack,
   output logic              busy,
   output logic              done,
   output logic              irq
);
   localparam int CNT_BITS = (CHANNEL == 3) ? 16 : 14;
   localparam int CNT_W    = CNT_BITS + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << CNT_BITS;

   generate
      if (CHANNEL < 0 || CHANNEL > 3) begin : g_bad_chan
         $error("CHANNEL must be 0..3");
      end
      if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must be 16..32");
      end
   endgenerate

   logic [ADDR_W-1:0]   src_q, dst_q, src_w, dst_w, src_nxt, dst_nxt, raw_addr;
   logic [CNT_BITS-1:0] cnt_q;
   logic [CNT_W-1:0]    cnt_w, cnt_load;
   step_e               dmode, smode;
   logic                rpt, word, irq_en, en, en_rise;
   logic                last_ack, hw_en_clr, rerun;
   logic [31:0]         data_q;
   seq_e                state;

   dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_BITS(CNT_BITS)) u_regs (
      .clk, .rst_n,
      .we(reg_we), .wsel(reg_wsel), .wdata(reg_wdata),
      .rsel(reg_rsel), .rdata(reg_rdata),
      .hw_en_clr,
      .src_q, .dst_q, .cnt_q,
      .dmode, .smode, .rpt, .word, .irq_en, .en, .en_rise
   );

   dma_addr_step #(.ADDR_W(ADDR_W), .IS_SRC(1'b1)) u_src_step (
      .addr(src_w), .mode(smode), .word, .nxt(src_nxt)
   );

   dma_addr_step #(.ADDR_W(ADDR_W), .IS_SRC(1'b0)) u_dst_step (
      .addr(dst_w), .mode(dmode), .word, .nxt(dst_nxt)
   );

   assign cnt_load  = (cnt_q == '0) ? CNT_MAX : CNT_W'(cnt_q);
   assign last_ack  = (state == ST_WR) && bus_ack && (cnt_w == CNT_W'(1));
   assign hw_en_clr = last_ack && !rpt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         src_w  <= '0;
         dst_w  <= '0;
         cnt_w  <= '0;
         data_q <= '0;
         rerun  <= 1'b0;
         done   <= 1'b0;
         irq    <= 1'b0;
      end else begin
         done <= 1'b0;
         irq  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (en_rise) begin
                  src_w <= src_q;
                  dst_w <= dst_q;
                  cnt_w <= cnt_load;
                  rerun <= 1'b0;
               end else if (trig && en) begin
                  if (rerun) begin
                     cnt_w <= cnt_load;
                     if (dmode == STEP_INC_RLD) dst_w <= dst_q;
                  end
                  state <= ST_RD;
               end
            end
            ST_RD: begin
               if (bus_ack) begin
                  data_q <= bus_rdata;
                  state  <= ST_WR;
               end
            end
            default: begin
               if (bus_ack) begin
                  src_w <= src_nxt;
                  dst_w <= dst_nxt;
                  cnt_w <= cnt_w - CNT_W'(1);
                  if (last_ack) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                     irq   <= irq_en;
                     rerun <= 1'b1;
                  end else begin
                     state <= ST_RD;
                  end
               end
            end
         endcase
      end
   end

   assign raw_addr  = (state == ST_WR) ? dst_w : src_w;
   assign bus_addr  = raw_addr & ~(word ? ADDR_W'(3) : ADDR_W'(1));
   assign bus_req   = (state != ST_IDLE);
   assign bus_we    = (state == ST_WR);
   assign bus_size  = word;
   assign bus_wdata = data_q;
   assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              irq,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_size,
   input logic              bus_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [1:0]        reg_rsel,
   input logic [31:0]       reg_rdata
);
   assert_done_on_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_irq_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);
   assert_req_inside_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> busy);
   assert_word_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_size) |-> (bus_addr[1:0] == 2'b00));
   assert_half_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_size) |-> !bus_addr[0]);
   assert_hold_on_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
   assert_ctrl_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rsel == 2'd3) |-> (reg_rdata[4:0] == 5'b0));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk, .rst_n, .busy, .done, .irq, .bus_req, .bus_we, .bus_size, .bus_ack,
   .bus_addr, .bus_wdata, .reg_rsel, .reg_rdata
);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 7;
   // entry: src[95:64] dst[63:32] count[31:16] ctrl[15:0]
   localparam logic [95:0] VEC [NVEC] = '{
      {32'h0000_1000, 32'h0000_2000, 16'd4, 16'h8000},
      {32'h0000_3000, 32'h0000_4100, 16'd3, 16'h8420},
      {32'h0000_5010, 32'h0000_6000, 16'd5, 16'h80C0},
      {32'h0000_7000, 32'h0000_8000, 16'd2, 16'h8500},
      {32'h0000_9000, 32'h0000_A000, 16'd3, 16'h85E0},
      {32'h0000_B003, 32'h0000_C005, 16'd2, 16'h8000},
      {32'h0000_D002, 32'h0000_E003, 16'd2, 16'h8400}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0, trig = 1'b0;
   logic [1:0] reg_wsel = '0, reg_rsel = '0;
   logic [31:0] reg_wdata = '0, reg_rdata, bus_wdata, bus_rdata;
   logic bus_req, bus_we, bus_size, bus_ack, busy, done, irq;
   logic [31:0] bus_addr;
   logic ack_ok = 1'b1, stall = 1'b0;
   int errors = 0, checks = 0, cycles = 0, log_n = 0;
   logic [31:0] log_a [64];
   logic [31:0] log_d [64];
   logic seen_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_xfer_engine u_dma_xfer_engine (
      .clk, .rst_n, .reg_we, .reg_wsel, .reg_wdata, .reg_rsel, .reg_rdata,
      .trig, .bus_req, .bus_we, .bus_size, .bus_addr, .bus_wdata, .bus_rdata,
      .bus_ack, .busy, .done, .irq
   );

   assign bus_rdata = {~bus_addr[15:0], bus_addr[15:0]};
   assign bus_ack   = bus_req & ack_ok;

   always @(negedge clk) ack_ok <= stall ? ~ack_ok : 1'b1;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (bus_req && bus_we && bus_ack) begin
         log_a[log_n % 64] <= bus_addr;
         log_d[log_n % 64] <= bus_wdata;
         log_n <= log_n + 1;
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d expected<=150000 cycles", cycles);
      finish_run();
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_wsel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      reg_rsel = sel;
      #1 d = reg_rdata;
   endtask

   task automatic fire();
      @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   // waits at negedges until done is seen; returns 0 on timeout
   task automatic wait_done(output bit ok);
      ok = 1'b0;
      seen_irq = 1'b0;
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         if (irq) seen_irq = 1'b1;
         if (done) begin ok = 1'b1; break; end
      end
      chk(ok, "R10 done seen", {31'b0, ok}, 32'd1);
   endtask

   function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [1:0] mode,
                                            input bit word, input int i, input bit is_src);
      logic [31:0] b, st;
      b  = base & (word ? 32'hFFFF_FFFC : 32'hFFFF_FFFE);
      st = word ? 32'd4 : 32'd2;
      case (mode)
         2'd0: return b + st * i;
         2'd1: return b - st * i;
         2'd2: return b;
         default: return is_src ? b : b + st * i;
      endcase
   endfunction

   task automatic check_run(input int base, input int n, input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] ctrl, input int soff, input int doff, input string tag);
      logic [31:0] ea, es;
      chk(log_n - base == n, {tag, " R7 write count"}, log_n - base, n);
      for (int i = 0; i < n && i < 64; i++) begin
         ea = exp_addr(d, ctrl[6:5], ctrl[10], i + doff, 1'b0);
         es = exp_addr(s, ctrl[8:7], ctrl[10], i + soff, 1'b1);
         chk(log_a[(base + i) % 64] == ea, {tag, " R4 R6 R11 dst addr"}, log_a[(base + i) % 64], ea);
         chk(log_d[(base + i) % 64] == {~es[15:0], es[15:0]}, {tag, " R3 R5 data from src"},
             log_d[(base + i) % 64], {~es[15:0], es[15:0]});
      end
   endtask

   initial begin
      logic [31:0] v;
      bit ok;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         rd(2'(s), v);
         chk(v == 0, "R1 reset readback", v, 0);
      end
      chk(!busy && !done && !irq && !bus_req, "R10 reset outputs", {busy, done, irq, bus_req}, 0);

      // R1 control low bits dropped, register readback
      wr(2'd3, 32'h0000_401F);
      rd(2'd3, v);
      chk(v == 32'h4000, "R1 ctrl bits 4:0 read zero", v, 32'h4000);
      wr(2'd0, 32'h0000_1234);
      rd(2'd0, v);
      chk(v == 32'h1234, "R1 src readback", v, 32'h1234);
      // R7 count truncated to 14 bits
      wr(2'd2, 32'h0000_4005);
      rd(2'd2, v);
      chk(v == 32'h0005, "R7 count low 14 bits", v, 32'h5);
      // R2 trigger ignored while disabled
      base = log_n;
      fire();
      repeat (4) @(negedge clk);
      chk(!busy && log_n == base, "R2 trig ignored when disabled", log_n - base, 0);
      wr(2'd3, 32'h0);

      // table walk
      for (int k = 0; k < NVEC; k++) begin
         wr(2'd0, VEC[k][95:64]);
         wr(2'd1, VEC[k][63:32]);
         wr(2'd2, {16'h0, VEC[k][31:16]});
         wr(2'd3, {16'h0, VEC[k][15:0]});
         base = log_n;
         fire();
         wait_done(ok);
         check_run(base, int'(VEC[k][31:16]), VEC[k][95:64], VEC[k][63:32], VEC[k][15:0], 0, 0,
                   $sformatf("vec%0d", k));
         rd(2'd3, v);
         chk(v[15] == 1'b0, "R9 enable cleared without repeat", v, {16'h0, VEC[k][15:0]} & 32'h7FFF);
      end

      // R10 irq pulse with done, one cycle
      wr(2'd0, 32'h100); wr(2'd1, 32'h200); wr(2'd2, 32'd1);
      wr(2'd3, 32'hC000);
      fire();
      wait_done(ok);
      chk(irq && !busy, "R10 irq with done", {irq, busy}, 2'b10);
      @(negedge clk);
      chk(!done && !irq, "R10 pulses one cycle", {done, irq}, 0);

      // R8 repeat, destination continues; count reloaded from register
      wr(2'd0, 32'h100); wr(2'd1, 32'h200); wr(2'd2, 32'd2);
      wr(2'd3, 32'h8200);
      base = log_n;
      fire(); wait_done(ok);
      check_run(base, 2, 32'h100, 32'h200, 16'h8200, 0, 0, "rpt1");
      rd(2'd3, v);
      chk(v[15] == 1'b1, "R9 enable kept with repeat", v, 32'h8200);
      wr(2'd2, 32'd3);
      base = log_n;
      fire(); wait_done(ok);
      check_run(base, 3, 32'h100, 32'h200, 16'h8200, 2, 2, "R8 rpt2 continue");
      wr(2'd3, 32'h0);

      // R8 destination code 3 reloads destination, source continues
      wr(2'd0, 32'h180); wr(2'd1, 32'h300); wr(2'd2, 32'd2);
      wr(2'd3, 32'h8260);
      base = log_n;
      fire(); wait_done(ok);
      check_run(base, 2, 32'h180, 32'h300, 16'h8260, 0, 0, "rld1");
      base = log_n;
      fire(); wait_done(ok);
      check_run(base, 2, 32'h180, 32'h300, 16'h8260, 2, 0, "R8 rld2 dst restart");
      wr(2'd3, 32'h0);

      // R2 re-enable starts from register values
      wr(2'd3, 32'h8000);
      base = log_n;
      fire(); wait_done(ok);
      check_run(base, 2, 32'h180, 32'h300, 16'h8000, 0, 0, "R2 re-enable");

      // R12 wait states
      stall = 1'b1;
      wr(2'd0, 32'h400); wr(2'd1, 32'h800); wr(2'd2, 32'd3);
      wr(2'd3, 32'h8400);
      base = log_n;
      fire(); wait_done(ok);
      check_run(base, 3, 32'h400, 32'h800, 16'h8400, 0, 0, "R12 stalled");
      stall = 1'b0;

      // R7 count zero means 16384 transfers
      wr(2'd0, 32'h40); wr(2'd1, 32'h80); wr(2'd2, 32'd0);
      wr(2'd3, 32'h8140);
      base = log_n;
      fire(); wait_done(ok);
      chk(log_n - base == 16384, "R7 zero count max", log_n - base, 16384);
      chk(log_a[(log_n - 1) % 64] == 32'h80, "R4 hold dst", log_a[(log_n - 1) % 64], 32'h80);

      finish_run();
   end
endmodule